// File: doc/BRIEF.md
# Low-Power Lane State Controller

This block runs the low-power signalling of one serial display data lane. It drives the two single-ended line wires, and it watches them while the lane belongs to the peripheral. Every low-power state is a pair of wire levels. In this project a pair is written LP-xy, where x is the positive wire and y is the negative wire. A small one-cycle request interface asks for four things: sleep entry, sleep exit, a bus turnaround, or the start of high-speed operation. The status outputs give the current state code, the lane direction and an error pulse.

To enter ultra-low-power sleep, the block plays an escape entry on the wires. It then serialises a sleep command with spaced one-hot marks and parks the lane at LP-00. To leave sleep, it drives a timed wakeup mark and returns to stop. A turnaround hands the lane to the peripheral. The block then waits for the peripheral to give the lane back. All intervals come from one down-counter with parameterised limits:

- `T_LPX` is the length of one line step.
- `T_SETTLE` is the high-speed settle time.
- `T_WAKE` is the wakeup time. Its default of 125000 cycles is 1 ms at 125 MHz.

Top module: `lp_lane_ctrl`

## Requirements
- R1: After reset the lane is in stop: state code 0, wires driven to LP-11 (`line_oe_o`=1, `line_p_o`=1, `line_n_o`=1), `dir_fwd_o`=1, `hs_valid_o`=0 and `err_o`=0. The state codes are 0 stop, 1 escape, 2 sleep, 3 wakeup, 4 high-speed prepare, 5 high-speed, 6 turnaround and 7 reverse.
- R2: A sleep-exit request outside sleep has no effect. A high-speed-start request outside stop has no effect. A high-speed-end request outside high-speed has no effect.
- R3: A sleep request in stop drives the escape entry LP-10, LP-00, LP-01, LP-00. It then sends the command 0x1E, most significant bit first. Each 1 bit is a mark of LP-10 and each 0 bit is a mark of LP-01, and every mark is followed by an LP-00 space. Each of these 20 steps lasts `T_LPX` cycles, and the state code is 1 throughout.
- R4: After the last command space, the lane enters sleep (code 2). It holds LP-00 driven until a sleep-exit request arrives.
- R5: A sleep-exit request in sleep drives LP-10 for exactly `T_WAKE` cycles (code 3). The lane then returns to stop at LP-11.
- R6: A high-speed request in stop drives LP-01 for `T_LPX` cycles and LP-00 for `T_LPX` cycles. It then releases the wires for `T_SETTLE` cycles, all with code 4. After that, `hs_valid_o` rises with code 5 and the wires stay released. A high-speed-end request returns the lane to stop on the next cycle.
- R7: On lane 0, a turnaround request in stop drives LP-10, LP-00, LP-10, LP-00, each for `T_LPX` cycles (code 6). It then releases the wires. When the observed wires read LP-11, the state becomes reverse (code 7) with `dir_fwd_o`=0.
- R8: In reverse, an observed LP-10 followed by an observed LP-00 returns the lane to stop at LP-11. An observed LP-00 that does not follow an LP-10 is ignored.
- R9: A turnaround request is refused in two cases: the block is not lane 0, or the request is not accepted from stop. A refusal gives a one-cycle `err_o` pulse on the next cycle and does not change the state.
- R10: When requests arrive together in stop, sleep wins over turnaround, and turnaround wins over high-speed. A turnaround that loses to sleep is refused under R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_sleep | input | 1 | Request sleep entry (one cycle) |
| req_wake | input | 1 | Request sleep exit (one cycle) |
| req_turn | input | 1 | Request bus turnaround (one cycle) |
| req_hs | input | 1 | Request high-speed start (one cycle) |
| req_hs_end | input | 1 | Request end of high-speed (one cycle) |
| line_p_i | input | 1 | Observed positive wire level |
| line_n_i | input | 1 | Observed negative wire level |
| line_p_o | output | 1 | Driven positive wire level |
| line_n_o | output | 1 | Driven negative wire level |
| line_oe_o | output | 1 | Low-power driver enable |
| state_o | output | 3 | State code |
| dir_fwd_o | output | 1 | 1 when the host owns the lane |
| hs_valid_o | output | 1 | High-speed data may be treated as valid |
| err_o | output | 1 | One-cycle pulse when a turnaround is refused |

## Verification
The assertions assume that each request is a single-cycle pulse. They also assume that the observed wires equal the driven levels whenever the driver is enabled, so a peripheral only drives the wires after release. The bench resolves the observed wires as the driven value when `line_oe_o` is high, and as its own peripheral value otherwise. It changes the peripheral value only while the lane is released, and it also sends requests in states where they must be ignored or refused. A second instance built as a lane other than 0 is used to exercise the refusal path.

// File: rtl/lp_lane_ctrl.sv
module lp_lane_ctrl #(
  parameter bit          IS_LANE0  = 1'b1,
  parameter int unsigned T_LPX     = 4,
  parameter int unsigned T_SETTLE  = 12,
  parameter int unsigned T_WAKE    = 125000,
  parameter logic [7:0]  SLEEP_CMD = 8'h1E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_sleep,
  input  logic       req_wake,
  input  logic       req_turn,
  input  logic       req_hs,
  input  logic       req_hs_end,
  input  logic       line_p_i,
  input  logic       line_n_i,
  output logic       line_p_o,
  output logic       line_n_o,
  output logic       line_oe_o,
  output logic [2:0] state_o,
  output logic       dir_fwd_o,
  output logic       hs_valid_o,
  output logic       err_o
);
  localparam int unsigned TMAX = (T_WAKE > T_LPX) ? ((T_WAKE > T_SETTLE) ? T_WAKE : T_SETTLE)
                                                  : ((T_LPX > T_SETTLE) ? T_LPX : T_SETTLE);
  localparam int TW = $clog2(TMAX + 1);
  localparam int ESC_STEPS = 4 + 2 * 8;
  localparam int SW = $clog2(ESC_STEPS + 1);

  localparam logic [2:0] S_STOP = 3'd0, S_ESC = 3'd1, S_SLEEP = 3'd2, S_WAKE = 3'd3,
                         S_HSP  = 3'd4, S_HS  = 3'd5, S_TURN  = 3'd6, S_REV  = 3'd7;

  logic [2:0]    state;
  logic [SW-1:0] step;
  logic [TW-1:0] tmr;
  logic          seen10;
  logic          err_q;
  logic [1:0]    obs;
  logic [1:0]    lv;
  logic          oe;
  logic [1:0]    esc_lv;
  logic [SW-1:0] k;
  logic          turn_ok, turn_err, tmr_done;

  assign obs      = {line_p_i, line_n_i};
  assign tmr_done = (tmr == '0);
  assign turn_ok  = req_turn && IS_LANE0 && (state == S_STOP) && !req_sleep;
  assign turn_err = req_turn && !turn_ok;
  assign k        = step - SW'(4);

  always_comb begin
    esc_lv = 2'b00;
    if (step < SW'(4)) begin
      case (step[1:0])
        2'd0:    esc_lv = 2'b10;
        2'd2:    esc_lv = 2'b01;
        default: esc_lv = 2'b00;
      endcase
    end else if (!k[0]) begin
      esc_lv = SLEEP_CMD[3'd7 - k[3:1]] ? 2'b10 : 2'b01;
    end
  end

  always_comb begin
    oe = 1'b1;
    lv = 2'b11;
    case (state)
      S_ESC:   lv = esc_lv;
      S_SLEEP: lv = 2'b00;
      S_WAKE:  lv = 2'b10;
      S_HSP: begin
        if (step == SW'(0))      lv = 2'b01;
        else if (step == SW'(1)) lv = 2'b00;
        else begin oe = 1'b0; lv = 2'b00; end
      end
      S_HS:  begin oe = 1'b0; lv = 2'b00; end
      S_TURN: begin
        if (step < SW'(4)) lv = step[0] ? 2'b00 : 2'b10;
        else begin oe = 1'b0; lv = 2'b00; end
      end
      S_REV: begin oe = 1'b0; lv = 2'b00; end
      default: lv = 2'b11;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_STOP;
      step   <= '0;
      tmr    <= '0;
      seen10 <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= turn_err;
      case (state)
        S_STOP: begin
          if (req_sleep) begin
            state <= S_ESC;  step <= '0; tmr <= TW'(T_LPX - 1);
          end else if (turn_ok) begin
            state <= S_TURN; step <= '0; tmr <= TW'(T_LPX - 1);
          end else if (req_hs) begin
            state <= S_HSP;  step <= '0; tmr <= TW'(T_LPX - 1);
          end
        end
        S_ESC: begin
          if (tmr_done) begin
            if (step == SW'(ESC_STEPS - 1)) state <= S_SLEEP;
            else begin step <= step + 1'b1; tmr <= TW'(T_LPX - 1); end
          end else tmr <= tmr - 1'b1;
        end
        S_SLEEP: begin
          if (req_wake) begin state <= S_WAKE; tmr <= TW'(T_WAKE - 1); end
        end
        S_WAKE: begin
          if (tmr_done) state <= S_STOP;
          else tmr <= tmr - 1'b1;
        end
        S_HSP: begin
          if (tmr_done) begin
            if (step == SW'(0))      begin step <= SW'(1); tmr <= TW'(T_LPX - 1); end
            else if (step == SW'(1)) begin step <= SW'(2); tmr <= TW'(T_SETTLE - 1); end
            else state <= S_HS;
          end else tmr <= tmr - 1'b1;
        end
        S_HS: begin
          if (req_hs_end) state <= S_STOP;
        end
        S_TURN: begin
          if (step < SW'(4)) begin
            if (tmr_done) begin step <= step + 1'b1; tmr <= TW'(T_LPX - 1); end
            else tmr <= tmr - 1'b1;
          end else if (obs == 2'b11) begin
            state <= S_REV; seen10 <= 1'b0;
          end
        end
        default: begin
          if (obs == 2'b10) seen10 <= 1'b1;
          else if (obs == 2'b00) begin
            if (seen10) state <= S_STOP;
          end else seen10 <= 1'b0;
        end
      endcase
    end
  end

  assign line_p_o   = lv[1];
  assign line_n_o   = lv[0];
  assign line_oe_o  = oe;
  assign state_o    = state;
  assign dir_fwd_o  = (state != S_REV);
  assign hs_valid_o = (state == S_HS);
  assign err_o      = err_q;

  logic [TW-1:0] wake_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_run <= '0;
    else if (state == S_WAKE) wake_run <= wake_run + 1'b1;
    else wake_run <= '0;
  end

  p_esc_no_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_ESC) |-> !(line_p_o && line_n_o));
  p_sleep_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_SLEEP && !req_wake) |=> (state_o == S_SLEEP));
  p_wake_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == S_WAKE && state_o == S_STOP) |-> (wake_run == TW'(T_WAKE)));
  p_hs_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid_o |-> !line_oe_o);
  p_rev_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == S_REV && $past(state_o) != S_REV) |-> $past(line_p_i && line_n_i));
  p_rev_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_fwd_o) |-> !line_oe_o);
  p_turn_refused_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_turn && (!IS_LANE0 || state_o != S_STOP)) |=> err_o);
endmodule

// File: tb/lp_lane_ctrl_tb.sv
module lp_lane_ctrl_tb;
  localparam int LPX = 3, SET = 5, WAK = 40;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic r_sleep = 0, r_wake = 0, r_turn = 0, r_hs = 0, r_hs_end = 0;
  logic [1:0] periph = 2'b00;
  logic p_o, n_o, oe_o, dir_o, hsv_o, err_o;
  logic [2:0] st_o;
  logic [1:0] obs;
  assign obs = oe_o ? {p_o, n_o} : periph;

  lp_lane_ctrl #(.IS_LANE0(1'b1), .T_LPX(LPX), .T_SETTLE(SET), .T_WAKE(WAK)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_sleep(r_sleep), .req_wake(r_wake), .req_turn(r_turn),
    .req_hs(r_hs), .req_hs_end(r_hs_end), .line_p_i(obs[1]), .line_n_i(obs[0]),
    .line_p_o(p_o), .line_n_o(n_o), .line_oe_o(oe_o), .state_o(st_o),
    .dir_fwd_o(dir_o), .hs_valid_o(hsv_o), .err_o(err_o));

  logic nl_turn = 0;
  logic nl_p, nl_n, nl_oe, nl_dir, nl_hsv, nl_err;
  logic [2:0] nl_st;
  lp_lane_ctrl #(.IS_LANE0(1'b0), .T_LPX(LPX), .T_SETTLE(SET), .T_WAKE(WAK)) u_dut_nl (
    .clk(clk), .rst_n(rst_n), .req_sleep(1'b0), .req_wake(1'b0), .req_turn(nl_turn),
    .req_hs(1'b0), .req_hs_end(1'b0), .line_p_i(nl_p), .line_n_i(nl_n),
    .line_p_o(nl_p), .line_n_o(nl_n), .line_oe_o(nl_oe), .state_o(nl_st),
    .dir_fwd_o(nl_dir), .hs_valid_o(nl_hsv), .err_o(nl_err));

  int checks = 0, errors = 0;
  logic [8:0] eq[$];
  string tq[$];
  logic [8:0] steady;
  string stag;

  function automatic logic [8:0] pk(int s, bit oe, logic [1:0] l, bit d, bit h, bit e);
    return {e, 3'(s), oe, l, d, h};
  endfunction

  task automatic push(int n, logic [8:0] v, string t);
    for (int i = 0; i < n; i++) begin eq.push_back(v); tq.push_back(t); end
  endtask

  task automatic cyc();
    logic [8:0] exp_v, act;
    string t;
    @(negedge clk);
    if (eq.size() > 0) begin
      exp_v = eq.pop_front(); t = tq.pop_front();
      steady = exp_v & 9'h0FF; stag = t;
    end else begin
      exp_v = steady; t = stag;
    end
    act = {err_o, st_o, oe_o, p_o, n_o, dir_o, hsv_o};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", t, $time, act, exp_v);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic nl_check(bit exp_err, string t);
    checks++;
    if (nl_err !== exp_err || nl_st !== 3'd0 || nl_oe !== 1'b1) begin
      errors++;
      $display("FAIL %s nl actual err=%b st=%0d oe=%b expected err=%b st=0 oe=1",
               t, nl_err, nl_st, nl_oe, exp_err);
    end
  endtask

  task automatic expect_sleep_seq(string t);
    logic [7:0] cmd = 8'h1E;
    push(LPX, pk(1, 1, 2'b10, 1, 0, 0), t);
    push(LPX, pk(1, 1, 2'b00, 1, 0, 0), t);
    push(LPX, pk(1, 1, 2'b01, 1, 0, 0), t);
    push(LPX, pk(1, 1, 2'b00, 1, 0, 0), t);
    for (int b = 7; b >= 0; b--) begin
      push(LPX, pk(1, 1, cmd[b] ? 2'b10 : 2'b01, 1, 0, 0), t);
      push(LPX, pk(1, 1, 2'b00, 1, 0, 0), t);
    end
    push(1, pk(2, 1, 2'b00, 1, 0, 0), "R4");
  endtask

  task automatic do_wake();
    cyc(); r_wake = 1;
    push(WAK, pk(3, 1, 2'b10, 1, 0, 0), "R5");
    push(1, pk(0, 1, 2'b11, 1, 0, 0), "R5");
    cyc(); r_wake = 0;
    run(WAK + 3);
  endtask

  task automatic handback();
    cyc(); periph = 2'b10; run(3);
    periph = 2'b00;
    push(1, pk(0, 1, 2'b11, 1, 0, 0), "R8");
    run(4);
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    steady = pk(0, 1, 2'b11, 1, 0, 0); stag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nl_check(1'b0, "R1");
    run(3);
    // R2: inapplicable requests in stop
    r_wake = 1; r_hs_end = 1; cyc(); r_wake = 0; r_hs_end = 0;
    stag = "R2"; run(4);
    // R3/R4: sleep entry
    r_sleep = 1; expect_sleep_seq("R3"); cyc(); r_sleep = 0;
    run(20 * LPX + 5);
    // R2/R9 in sleep: hs ignored, turn refused
    r_hs = 1; stag = "R2"; cyc(); r_hs = 0; run(3);
    r_turn = 1; push(1, pk(2, 1, 2'b00, 1, 0, 1), "R9"); cyc(); r_turn = 0;
    run(3);
    do_wake();
    // R6: high-speed entry and exit
    r_hs = 1;
    push(LPX, pk(4, 1, 2'b01, 1, 0, 0), "R6");
    push(LPX, pk(4, 1, 2'b00, 1, 0, 0), "R6");
    push(SET, pk(4, 0, 2'b00, 1, 0, 0), "R6");
    push(1, pk(5, 0, 2'b00, 1, 1, 0), "R6");
    cyc(); r_hs = 0;
    run(2 * LPX + SET + 4);
    r_wake = 1; stag = "R2"; cyc(); r_wake = 0; run(2);
    r_hs_end = 1; push(1, pk(0, 1, 2'b11, 1, 0, 0), "R6"); cyc(); r_hs_end = 0;
    run(3);
    // R7/R8: turnaround and handback
    r_turn = 1;
    push(LPX, pk(6, 1, 2'b10, 1, 0, 0), "R7");
    push(LPX, pk(6, 1, 2'b00, 1, 0, 0), "R7");
    push(LPX, pk(6, 1, 2'b10, 1, 0, 0), "R7");
    push(LPX, pk(6, 1, 2'b00, 1, 0, 0), "R7");
    push(1, pk(6, 0, 2'b00, 1, 0, 0), "R7");
    cyc(); r_turn = 0;
    run(4 * LPX + 5);
    periph = 2'b11; push(1, pk(7, 0, 2'b00, 0, 0, 0), "R7"); run(4);
    periph = 2'b00; stag = "R8"; run(4);
    periph = 2'b11; run(2);
    handback();
    // R10: sleep beats turn, refused turn flags error
    r_sleep = 1; r_turn = 1;
    expect_sleep_seq("R10");
    eq[0] = pk(1, 1, 2'b10, 1, 0, 1);
    cyc(); r_sleep = 0; r_turn = 0;
    run(20 * LPX + 4);
    do_wake();
    // R10: turn beats hs
    r_turn = 1; r_hs = 1;
    push(4 * LPX, pk(6, 1, 2'b10, 1, 0, 0), "R10");
    for (int i = 0; i < 4 * LPX; i++) if ((i / LPX) % 2 == 1) eq[i] = pk(6, 1, 2'b00, 1, 0, 0);
    push(1, pk(6, 0, 2'b00, 1, 0, 0), "R10");
    cyc(); r_turn = 0; r_hs = 0;
    run(4 * LPX + 2);
    periph = 2'b11; push(1, pk(7, 0, 2'b00, 0, 0, 0), "R7"); run(3);
    handback();
    // R9: non-lane-0 instance refuses turnaround
    @(negedge clk); nl_turn = 1;
    @(negedge clk); nl_turn = 0; nl_check(1'b1, "R9");
    @(negedge clk); nl_check(1'b0, "R9");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule